// File: doc/BRIEF.md
# Register-Direct Integer Instruction Executor

This block runs a small set of 32-bit integer instructions from the common desktop instruction encoding. Every instruction it takes works on registers only. Bytes arrive one at a time on a valid/ready stream: an opcode byte, or the escape byte 0x0F followed by a second opcode byte, and then one operand-selector byte. The block keeps eight 32-bit registers and three status flags (sign, zero, overflow). When the selector byte is accepted, the operation reads its operands, writes its results and updates its flags at that same clock edge.

The supported operations are add, subtract, AND, OR, XOR, compare, copy, swap, complement, a widening unsigned multiply into a register pair, and a two-operand multiply that keeps the low half of the product. A one-cycle `done` pulse marks each completed instruction. A one-cycle `err` pulse marks each rejected instruction: an unknown opcode, an unsupported addressing mode, or an unsupported sub-operation. A debug port lets the environment load any register and read any register.

Top module: `regdirect_exec`

## Requirements
- R1: During reset and after it, all eight registers read 0, `flag_sf`/`flag_zf`/`flag_of` are 0, and `done` and `err` are low. `in_ready` is always high.
- R2: The selector byte is laid out as follows. Bits 7:6 are the mode and must be 3. Bits 5:3 are the "reg" operand. Bits 2:0 are the "rm" operand. Register numbers 0..7 name A, C, D, B, SP, BP, SI and DI in that order. The multiply uses register 0 (A) and register 2 (D).
- R3: Opcodes 0x01, 0x29, 0x21, 0x09 and 0x31 write rm+reg, rm-reg, rm&reg, rm|reg and rm^reg into rm. SF is bit 31 of the result and ZF is set when the result is zero.
- R4: For add and subtract, OF is set on signed overflow. For AND, OR and XOR, OF is cleared.
- R5: Opcode 0x39 computes rm-reg and sets SF, ZF and OF as subtract does. It writes no register.
- R6: Opcode 0x89 copies reg into rm. Opcode 0x87 swaps reg and rm. Neither changes the flags.
- R7: Opcode 0xF7 with reg=2 writes ~rm into rm, sets SF from bit 31, sets ZF when the result is zero, and clears OF.
- R8: Opcode 0xF7 with reg=4 multiplies A by rm as unsigned numbers. The low 32 bits go to A and the high 32 bits go to D. OF is set when the high half is nonzero. SF and ZF are kept.
- R9: The byte pair 0x0F 0xAF writes the low 32 bits of reg*rm into reg. SF and ZF come from that low word. OF is set when the signed 64-bit product differs from the sign-extended low word.
- R10: The instruction is rejected when the mode field is not 3, when opcode 0xF7 has a reg value other than 2 or 4, when the first byte is not a known opcode, or when the byte after 0x0F is not 0xAF. A rejected instruction pulses `err` for one cycle, writes no register and leaves the flags unchanged.
- R11: `done` is high for exactly the one cycle after the selector byte is accepted. In that cycle the new register values and flags are already visible.
- R12: While `dbg_we` is high, `dbg_wdata` is written into register `dbg_sel` at the next edge. `dbg_rdata` always shows register `dbg_sel`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction byte valid |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte accepted (always high) |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| err | output | 1 | Instruction rejected (one-cycle pulse) |
| flag_sf | output | 1 | Sign flag |
| flag_zf | output | 1 | Zero flag |
| flag_of | output | 1 | Overflow flag |
| dbg_sel | input | 3 | Debug register select |
| dbg_we | input | 1 | Debug register write enable |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |

## Verification
A wrong byte-sequencer state shows up at the ports straight away. Either `done` or `err` fires on the wrong byte, or it does not fire at all, in the cycle after the byte that should have ended the instruction. A wrong operand index or a wrong result shows up on `dbg_rdata` in the cycle after `done`, while the flags show a wrong sign, zero or overflow decision in that same cycle. A stray write from a rejected instruction, or a stray flag update from a copy or a swap, leaves a changed value behind. The bench finds it by reading the registers back right after the pulse.

// File: rtl/regdirect_exec.sv
module regdirect_exec #(
  parameter int XLEN = 32,
  parameter int NREG = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            done,
  output logic            err,
  output logic            flag_sf,
  output logic            flag_zf,
  output logic            flag_of,
  input  logic [2:0]      dbg_sel,
  input  logic            dbg_we,
  input  logic [XLEN-1:0] dbg_wdata,
  output logic [XLEN-1:0] dbg_rdata
);
  localparam int IW = $clog2(NREG);
  localparam logic [7:0] OP_ADD = 8'h01, OP_SUB = 8'h29, OP_AND = 8'h21,
                         OP_OR  = 8'h09, OP_XOR = 8'h31, OP_CMP = 8'h39,
                         OP_MOV = 8'h89, OP_XCH = 8'h87, OP_GRP = 8'hF7,
                         OP_ESC = 8'h0F, OP_MUL2 = 8'hAF;
  localparam logic [IW-1:0] IDX_A = IW'(0), IDX_D = IW'(2);

  typedef enum logic [1:0] {ST_OP, ST_ESC, ST_SEL} st_t;

  st_t            st_q;
  logic [7:0]     op_q;
  logic [XLEN-1:0] rf [NREG];

  logic [1:0]     md;
  logic [IW-1:0]  rg, rm;
  logic [XLEN-1:0] va, vb, va_d;
  logic [XLEN:0]  sum, dif;
  logic [2*XLEN-1:0] pu, ps;

  logic           bad, w1, w2, fset, sf_n, zf_n, of_n;
  logic [IW-1:0]  i1, i2;
  logic [XLEN-1:0] d1, d2;
  logic           known, exec, fire, rej;

  assign in_ready = 1'b1;
  assign md   = in_data[7:6];
  assign rg   = in_data[5:3];
  assign rm   = in_data[2:0];
  assign va   = rf[rm];
  assign vb   = rf[rg];
  assign va_d = rf[IDX_A];
  assign sum  = {1'b0, va} + {1'b0, vb};
  assign dif  = {1'b0, va} - {1'b0, vb};
  assign pu   = {{XLEN{1'b0}}, va_d} * {{XLEN{1'b0}}, va};
  assign ps   = $signed({{XLEN{vb[XLEN-1]}}, vb}) * $signed({{XLEN{va[XLEN-1]}}, va});
  assign dbg_rdata = rf[dbg_sel];

  always_comb begin
    bad = 1'b0; w1 = 1'b0; w2 = 1'b0; fset = 1'b0;
    i1 = rm; i2 = rg; d1 = '0; d2 = '0;
    sf_n = flag_sf; zf_n = flag_zf; of_n = flag_of;
    case (op_q)
      OP_ADD: begin
        w1 = 1'b1; d1 = sum[XLEN-1:0]; fset = 1'b1;
        of_n = (va[XLEN-1] == vb[XLEN-1]) && (d1[XLEN-1] != va[XLEN-1]);
      end
      OP_SUB, OP_CMP: begin
        w1 = (op_q == OP_SUB); d1 = dif[XLEN-1:0]; fset = 1'b1;
        of_n = (va[XLEN-1] != vb[XLEN-1]) && (d1[XLEN-1] != va[XLEN-1]);
      end
      OP_AND: begin w1 = 1'b1; d1 = va & vb; fset = 1'b1; of_n = 1'b0; end
      OP_OR:  begin w1 = 1'b1; d1 = va | vb; fset = 1'b1; of_n = 1'b0; end
      OP_XOR: begin w1 = 1'b1; d1 = va ^ vb; fset = 1'b1; of_n = 1'b0; end
      OP_MOV: begin w1 = 1'b1; d1 = vb; end
      OP_XCH: begin w1 = 1'b1; d1 = vb; w2 = 1'b1; d2 = va; end
      OP_GRP: begin
        if (rg == 3'd2) begin
          w1 = 1'b1; d1 = ~va; fset = 1'b1; of_n = 1'b0;
        end else if (rg == 3'd4) begin
          w1 = 1'b1; i1 = IDX_A; d1 = pu[XLEN-1:0];
          w2 = 1'b1; i2 = IDX_D; d2 = pu[2*XLEN-1:XLEN];
          of_n = |d2;
        end else begin
          bad = 1'b1;
        end
      end
      OP_MUL2: begin
        w1 = 1'b1; i1 = rg; d1 = ps[XLEN-1:0]; fset = 1'b1;
        of_n = ps[2*XLEN-1:XLEN] != {XLEN{d1[XLEN-1]}};
      end
      default: bad = 1'b1;
    endcase
    if (fset) begin
      sf_n = d1[XLEN-1];
      zf_n = (d1 == '0);
    end
  end

  always_comb begin
    case (in_data)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
      OP_CMP, OP_MOV, OP_XCH, OP_GRP: known = 1'b1;
      default: known = 1'b0;
    endcase
  end

  assign exec = in_valid && (st_q == ST_SEL);
  assign fire = exec && (md == 2'd3) && !bad;
  assign rej  = (exec && !fire)
             || (in_valid && st_q == ST_OP && !known && in_data != OP_ESC)
             || (in_valid && st_q == ST_ESC && in_data != OP_MUL2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OP;
      op_q <= '0;
    end else if (in_valid) begin
      case (st_q)
        ST_OP: begin
          op_q <= in_data;
          if (in_data == OP_ESC) st_q <= ST_ESC;
          else if (known)        st_q <= ST_SEL;
        end
        ST_ESC: begin
          op_q <= in_data;
          st_q <= (in_data == OP_MUL2) ? ST_SEL : ST_OP;
        end
        default: st_q <= ST_OP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) rf[k] <= '0;
    end else begin
      if (dbg_we)      rf[dbg_sel] <= dbg_wdata;
      if (fire && w1)  rf[i1] <= d1;
      if (fire && w2)  rf[i2] <= d2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0; err <= 1'b0;
      flag_sf <= 1'b0; flag_zf <= 1'b0; flag_of <= 1'b0;
    end else begin
      done <= fire;
      err  <= rej;
      if (fire) begin
        flag_sf <= sf_n; flag_zf <= zf_n; flag_of <= of_n;
      end
    end
  end
endmodule

module regdirect_exec_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            done,
  input logic            err,
  input logic            flag_sf,
  input logic            flag_zf,
  input logic            flag_of,
  input logic [2:0]      dbg_sel,
  input logic            dbg_we,
  input logic [XLEN-1:0] dbg_rdata
);
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !done); // R10
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({flag_sf, flag_zf, flag_of})); // R10
  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(dbg_we) && $stable(dbg_sel)) |-> $stable(dbg_rdata)); // R12
endmodule

bind regdirect_exec regdirect_exec_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err),
  .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
  .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_rdata(dbg_rdata)
);

// File: tb/regdirect_exec_tb.sv
module regdirect_exec_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, done, err, flag_sf, flag_zf, flag_of;
  logic [2:0]  dbg_sel = '0;
  logic        dbg_we = 1'b0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] expq[$];
  logic [31:0] m [8];
  logic msf = 0, mzf = 0, mof = 0;

  always #2.5 clk = ~clk;

  regdirect_exec u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .done(done), .err(err),
    .flag_sf(flag_sf), .flag_zf(flag_zf), .flag_of(flag_of),
    .dbg_sel(dbg_sel), .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected outcome per done/err pulse (R11, R10)
  always @(negedge clk) begin
    if (rst_n && (done || err)) begin
      if (expq.size() == 0) begin
        check("R11 unexpected pulse", {28'd0, done, err, 2'd0}, 32'd0);
      end else begin
        logic [3:0] e;
        e = expq.pop_front();
        check("R11 outcome err/sf/zf/of", {28'd0, err, flag_sf, flag_zf, flag_of}, {28'd0, e});
        check("R11 done pulse", {31'd0, done}, {31'd0, ~e[3]});
      end
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
  endtask

  task automatic load(input int r, input logic [31:0] v);
    @(negedge clk);
    dbg_we = 1'b1; dbg_sel = 3'(r); dbg_wdata = v;
    @(negedge clk);
    dbg_we = 1'b0;
    m[r] = v;
  endtask

  task automatic check_reg(input string req, input int r);
    dbg_sel = 3'(r);
    #1;
    check(req, dbg_rdata, m[r]);
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < 8; r++) check_reg(req, r);
  endtask

  // driver with reference model from the requirements
  task automatic instr(input int n, input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    logic [7:0] op, sel;
    logic [31:0] a, b, res;
    logic [63:0] p;
    logic e;
    int rg, rm;
    e = 1'b0;
    if (n == 1) begin
      op = b0; sel = 8'h00; e = 1'b1;
    end else if (n == 3) begin
      op = 8'hAF; sel = b2;
    end else begin
      op = b0; sel = b1;
      if (b0 == 8'h0F) e = 1'b1;
    end
    rg = int'(sel[5:3]); rm = int'(sel[2:0]);
    a = m[rm]; b = m[rg];
    if (sel[7:6] != 2'd3) e = 1'b1;
    if (op == 8'hF7 && rg != 2 && rg != 4) e = 1'b1;
    if (!e) begin
      case (op)
        8'h01: begin res = a + b; m[rm] = res; msf = res[31]; mzf = (res == 0);
                     mof = (a[31] == b[31]) && (res[31] != a[31]); end
        8'h29, 8'h39: begin res = a - b; if (op == 8'h29) m[rm] = res;
                     msf = res[31]; mzf = (res == 0);
                     mof = ($signed({a[31], a}) - $signed({b[31], b})) != $signed({res[31], res}); end
        8'h21: begin res = a & b; m[rm] = res; msf = res[31]; mzf = (res == 0); mof = 0; end
        8'h09: begin res = a | b; m[rm] = res; msf = res[31]; mzf = (res == 0); mof = 0; end
        8'h31: begin res = a ^ b; m[rm] = res; msf = res[31]; mzf = (res == 0); mof = 0; end
        8'h89: m[rm] = b;
        8'h87: begin m[rm] = b; m[rg] = a; end
        8'hF7: begin
          if (rg == 2) begin res = ~a; m[rm] = res; msf = res[31]; mzf = (res == 0); mof = 0; end
          else begin p = 64'(m[0]) * 64'(a); m[0] = p[31:0]; m[2] = p[63:32]; mof = (p[63:32] != 0); end
        end
        default: begin
          p = 64'($signed(b) * $signed(a));
          p = $signed({{32{b[31]}}, b}) * $signed({{32{a[31]}}, a});
          res = p[31:0]; m[rg] = res; msf = res[31]; mzf = (res == 0);
          mof = p[63:32] != {32{res[31]}};
        end
      endcase
    end
    expq.push_back({e, msf, mzf, mof});
    put_byte(b0);
    if (n >= 2) put_byte(b1);
    if (n >= 3) put_byte(b2);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < 8; r++) m[r] = '0;
    repeat (3) @(negedge clk);
    check("R1 done low in reset", {30'd0, done, err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 flags clear", {29'd0, flag_sf, flag_zf, flag_of}, 32'd0);
    check("R1 ready", {31'd0, in_ready}, 32'd1);
    check_all("R1 regs clear");

    load(0, 32'h10); load(3, 32'h1);
    check_reg("R12 debug load", 3);
    instr(2, 8'h01, 8'hD8, 8'h00);                 // R3 add B into A
    check("R3 add example", m[0], 32'h11);
    check_all("R3 add regs");

    load(0, 32'h0a0b0c0d); load(3, 32'ha0b0c0d0);
    instr(2, 8'h09, 8'hD8, 8'h00);                 // R3 or
    check("R3 or example", m[0], 32'haabbccdd);
    check_reg("R3 or reg", 0);
    load(0, 32'h0a0b0c0d); load(3, 32'haabbc0d0);
    instr(2, 8'h31, 8'hD8, 8'h00); check_reg("R3 xor", 0);
    load(0, 32'h0a0b0c0d); load(3, 32'h000000ff);
    instr(2, 8'h21, 8'hD8, 8'h00); check_reg("R3 and", 0);
    load(6, 32'h5); load(7, 32'h5);
    instr(2, 8'h29, 8'hFE, 8'h00); check_reg("R3 sub to zero SI", 6);  // rm=6 reg=7

    load(1, 32'h7fffffff); load(5, 32'h1);
    instr(2, 8'h01, 8'hE9, 8'h00); check_reg("R4 add overflow", 1);    // reg=5 rm=1
    load(1, 32'h80000000);
    instr(2, 8'h29, 8'hE9, 8'h00); check_reg("R4 sub overflow", 1);
    load(1, 32'hffffffff); load(5, 32'hffffffff);
    instr(2, 8'h31, 8'hE9, 8'h00); check_reg("R4 xor clears OF", 1);

    load(0, 32'h0a0b0c0d); load(3, 32'h0a0b0c07);
    instr(2, 8'h39, 8'hD8, 8'h00); check_all("R5 cmp greater no write");
    load(0, 32'h0a0b0c07); load(3, 32'h0a0b0c0d);
    instr(2, 8'h39, 8'hD8, 8'h00); check_all("R5 cmp lesser");
    load(3, 32'h0a0b0c07);
    instr(2, 8'h39, 8'hD8, 8'h00); check_all("R5 cmp equal");
    load(0, 32'h80000000); load(3, 32'h1);
    instr(2, 8'h39, 8'hD8, 8'h00); check_all("R5 cmp overflow");

    load(3, 32'haf);
    instr(2, 8'h89, 8'hD8, 8'h00); check_all("R6 mov");
    load(0, 32'h2e);
    instr(2, 8'h87, 8'hD8, 8'h00); check_all("R6 xchg");
    instr(2, 8'h87, 8'hDB, 8'h00); check_all("R6 xchg same reg");

    load(3, 32'h0f0f00ff);
    instr(2, 8'hF7, 8'hD3, 8'h00);
    check("R7 not example", m[3], 32'hf0f0ff00); check_reg("R7 not reg", 3);
    load(4, 32'hffffffff);
    instr(2, 8'hF7, 8'hD4, 8'h00); check_reg("R7 not to zero", 4);

    load(0, 32'h4); load(1, 32'h3); load(2, 32'hdead);
    instr(2, 8'hF7, 8'hE1, 8'h00);
    check("R8 mul example", m[0], 32'h0c); check_all("R8 mul regs");
    load(0, 32'hffffffff); load(1, 32'h2);
    instr(2, 8'hF7, 8'hE1, 8'h00); check_all("R8 mul high half");

    load(0, 32'h4); load(3, 32'h2);
    instr(3, 8'h0F, 8'hAF, 8'hD8); check_all("R9 imul");
    load(3, 32'h10000); load(0, 32'h10000);
    instr(3, 8'h0F, 8'hAF, 8'hD8); check_all("R9 imul overflow");
    load(3, 32'hfffffffe); load(0, 32'h3);
    instr(3, 8'h0F, 8'hAF, 8'hD8); check_all("R9 imul negative");

    load(0, 32'h1234); load(3, 32'h1);
    instr(2, 8'h01, 8'h58, 8'h00); check_all("R10 mode 1 rejected");
    instr(2, 8'h01, 8'h18, 8'h00); check_all("R10 mode 0 rejected");
    instr(2, 8'hF7, 8'hC0, 8'h00); check_all("R10 bad subop");
    instr(1, 8'h90, 8'h00, 8'h00); check_all("R10 unknown opcode");
    instr(2, 8'h0F, 8'h12, 8'h00); check_all("R10 bad escape");
    instr(2, 8'h01, 8'hD8, 8'h00); check_all("R2 recovers after reject");

    repeat (3) @(negedge clk);
    check("R11 all outcomes seen", expq.size(), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule